// File: doc/BRIEF.md
# Multi-Hart Run Control Status

This block keeps the run-control view of up to `NUM_HARTS` processor harts for a debug controller. For each hart it remembers whether the hart is halted, whether it has acknowledged the last resume, whether it has been reset, and which halt group it belongs to. A debugger reaches the block through a small word-wide register port. Writing the control word picks the harts to act on and drives their halt-request lines and resume flags. The harts report halt, resume and reset events back on per-hart pulse inputs.

Harts are picked either by one index or, when array selection is on, by that index together with a hart mask. The mask is read and written 32 harts at a time through a window. An index may name a hart that does not exist, and the status word says so. The status word folds the state of every selected existing hart into all/any pairs. Harts that share a nonzero halt group stop together: when one member reports halted, the others that are still running receive a halt request.

Top module: `hart_runctl`

## Requirements
- R1: After reset every hart is running, has no resume acknowledge, no have-reset flag and group 0. The control word, the window select and the mask are zero, no halt request or resume flag is raised, and the status word reads 0x00C.
- R2: The control word (address 0) holds active at bit 0, halt at bit 1, resume at bit 2, array-select at bit 3 and the hart index at bit 8 upward. The resume bit always reads back 0. A hart is selected when its number equals the index, or when array-select is set and its mask bit is 1.
- R3: The status word (address 1) has these bits: 0 all-halted, 1 any-halted, 2 all-running, 3 any-running, 4 all-resumeack, 5 any-resumeack, 6 all-nonexistent, 7 any-nonexistent, 8 all-have-reset, 9 any-have-reset. The all-bits start at 1 and the any-bits at 0, and each selected existing hart updates the halted/running, resume-ack and have-reset pairs.
- R4: An index at or above `NUM_HARTS` sets any-nonexistent. If no existing hart is selected, all-nonexistent stays 1.
- R5: The halt-request output of a hart is high while active and halt are set in the control word and the hart is selected.
- R6: A control write with active and resume set clears the resume acknowledge of each selected hart and raises its resume flag. A resuming pulse from a hart clears its halted state and its flag and sets its resume acknowledge.
- R7: A halted pulse marks the hart halted. If the hart was running and its group is nonzero, every other running hart of that group gets a halt request. That request holds until the hart itself reports halted or reset.
- R8: A reset pulse from a hart sets its have-reset flag, clears halted, returns its group to 0 and drops its pending group halt request.
- R9: The window select (address 2) picks mask bits 32*sel to 32*sel+31. The window word (address 3) reads and writes them. Bits for harts at or above `NUM_HARTS` read 0, and writes to them have no effect.
- R10: The group word (address 4) writes the group of the indexed hart from bits [GROUP_W-1:0], and only when bit 31 is set and groups are enabled. A read returns the group of the indexed hart, or 0 if that hart does not exist.
- R11: A control write with active clear stores zero in every control field and issues neither a resume nor a halt request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| hartHalted | input | NUM_HARTS | Per-hart pulse: hart entered halt |
| hartResuming | input | NUM_HARTS | Per-hart pulse: hart is resuming |
| hartResetEvt | input | NUM_HARTS | Per-hart pulse: hart was reset |
| haltReq | output | NUM_HARTS | Per-hart halt request level |
| resumeReq | output | NUM_HARTS | Per-hart pending resume flag |

## Verification
The bench builds the block with 36 harts and 4-bit groups, with array selection and groups enabled. At 36 harts the mask spans two windows and the second window is only partly populated, so the read-as-zero rule for missing harts can be seen at the port. The 6-bit index also reaches values such as 40 that name no hart. That lets the same run cover the nonexistent-status corner, mixed halted/running selections over a mask, and group halt spreading through three harts of one group while a group-0 hart stays isolated.

// File: rtl/hart_runctl_pkg.sv
package hart_runctl_pkg;

  typedef enum logic [2:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_STATUS = 3'd1,
    ADDR_WINSEL = 3'd2,
    ADDR_WINDOW = 3'd3,
    ADDR_GROUP  = 3'd4
  } rcAddr_e;

  localparam int CTRL_SEL_LSB = 8;
  localparam int GROUP_WE_BIT = 31;

  // control -> datapath strobes and effective control levels
  typedef struct packed {
    logic active;
    logic haltLvl;
    logic arraySel;
    logic resumeGo;
    logic maskWr;
    logic groupWr;
  } rcStrobe_t;

endpackage

// File: rtl/hart_runctl_ctrl.sv
module hart_runctl_ctrl
  import hart_runctl_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int WSEL_W   = 1,
  parameter bit ARRAY_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output rcStrobe_t         strobes,
  output logic [SEL_W-1:0]  sel,
  output logic [WSEL_W-1:0] winSel
);

  logic             activeQ, haltQ, arrQ;
  logic [SEL_W-1:0] selQ;
  logic             activeD, haltD, arrD;
  logic [SEL_W-1:0] selD;
  logic             ctrlWr;
  logic             arrayOn;
  logic             unusedBits;

  assign arrayOn    = ARRAY_EN;
  assign ctrlWr     = regWe && (regAddr == ADDR_CTRL);
  assign unusedBits = ^{regWdata[7:4], regWdata[30:CTRL_SEL_LSB+SEL_W]};

  // effective control values: a write takes effect in its own cycle
  always_comb begin
    activeD = activeQ;
    haltD   = haltQ;
    arrD    = arrQ;
    selD    = selQ;
    if (ctrlWr) begin
      activeD = regWdata[0];
      haltD   = regWdata[0] & regWdata[1];
      arrD    = regWdata[0] & regWdata[3] & arrayOn;
      selD    = regWdata[0] ? regWdata[CTRL_SEL_LSB +: SEL_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      haltQ   <= 1'b0;
      arrQ    <= 1'b0;
      selQ    <= '0;
      winSel  <= '0;
    end else begin
      activeQ <= activeD;
      haltQ   <= haltD;
      arrQ    <= arrD;
      selQ    <= selD;
      if (regWe && (regAddr == ADDR_WINSEL)) winSel <= regWdata[WSEL_W-1:0];
    end
  end

  always_comb begin
    strobes.active   = activeD;
    strobes.haltLvl  = haltD;
    strobes.arraySel = arrD;
    strobes.resumeGo = ctrlWr & regWdata[0] & regWdata[2];
    strobes.maskWr   = regWe && (regAddr == ADDR_WINDOW);
    strobes.groupWr  = regWe && (regAddr == ADDR_GROUP) && regWdata[GROUP_WE_BIT];
  end
  assign sel = selD;

endmodule

// File: rtl/hart_runctl_dp.sv
module hart_runctl_dp
  import hart_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int SEL_W     = 2,
  parameter int WSEL_W    = 1,
  parameter int GROUP_W   = 5,
  parameter bit ARRAY_EN  = 1'b1,
  parameter bit GROUPS_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rcStrobe_t            strobes,
  input  logic [SEL_W-1:0]     sel,
  input  logic [WSEL_W-1:0]    winSel,
  input  logic [2:0]           regAddr,
  input  logic [31:0]          regWdata,
  input  logic [NUM_HARTS-1:0] hartHalted,
  input  logic [NUM_HARTS-1:0] hartResuming,
  input  logic [NUM_HARTS-1:0] hartResetEvt,
  output logic [31:0]          regRdata,
  output logic [NUM_HARTS-1:0] haltReq,
  output logic [NUM_HARTS-1:0] resumeReq
);

  logic [NUM_HARTS-1:0] halted, resumeAck, haveReset, resumeFlag, grpReq;
  logic [NUM_HARTS-1:0] mask, selVec, grpHit;
  logic [GROUP_W-1:0]   grp [NUM_HARTS];
  logic [GROUP_W-1:0]   grpOfSel;
  logic                 selExists;
  logic                 groupsOn;
  logic [9:0]           statusBits;
  logic [31:0]          winWord;

  assign groupsOn = GROUPS_EN;

  // hart-array mask, present only when array selection is built
  generate
    if (ARRAY_EN) begin : g_mask
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mask <= '0;
        end else if (strobes.maskWr) begin
          for (int i = 0; i < NUM_HARTS; i++) begin
            if (winSel == WSEL_W'(i / 32)) mask[i] <= regWdata[i % 32];
          end
        end
      end
    end else begin : g_nomask
      assign mask = '0;
    end
  endgenerate

  // selection, existence of the indexed hart, group halt spreading
  always_comb begin
    selExists = 1'b0;
    grpOfSel  = '0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      selVec[i] = (sel == SEL_W'(i)) || (strobes.arraySel && mask[i]);
      if (sel == SEL_W'(i)) begin
        selExists = 1'b1;
        grpOfSel  = grp[i];
      end
    end
    for (int i = 0; i < NUM_HARTS; i++) begin
      grpHit[i] = 1'b0;
      for (int j = 0; j < NUM_HARTS; j++) begin
        if (j != i && hartHalted[j] && !halted[j] && grp[j] != '0 &&
            grp[j] == grp[i] && !halted[i])
          grpHit[i] = 1'b1;
      end
    end
  end

  // per-hart state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halted     <= '0;
      resumeAck  <= '0;
      haveReset  <= '0;
      resumeFlag <= '0;
      grpReq     <= '0;
      for (int i = 0; i < NUM_HARTS; i++) grp[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (hartResetEvt[i]) begin
          halted[i]    <= 1'b0;
          haveReset[i] <= 1'b1;
          grp[i]       <= '0;
          grpReq[i]    <= 1'b0;
        end else begin
          if (hartResuming[i]) begin
            halted[i]     <= 1'b0;
            resumeAck[i]  <= 1'b1;
            resumeFlag[i] <= 1'b0;
          end else if (hartHalted[i]) begin
            halted[i] <= 1'b1;
            grpReq[i] <= 1'b0;
          end
          if (grpHit[i] && !hartHalted[i]) grpReq[i] <= 1'b1;
          if (strobes.resumeGo && selVec[i]) begin
            resumeAck[i]  <= 1'b0;
            resumeFlag[i] <= 1'b1;
          end
          if (groupsOn && strobes.groupWr && sel == SEL_W'(i))
            grp[i] <= regWdata[GROUP_W-1:0];
        end
      end
    end
  end

  // all/any summary over selected existing harts
  always_comb begin
    logic allH, anyH, allR, anyR, allA, anyA, allN, allHR, anyHR;
    allH = 1'b1; anyH = 1'b0; allR = 1'b1; anyR = 1'b0;
    allA = 1'b1; anyA = 1'b0; allN = 1'b1; allHR = 1'b1; anyHR = 1'b0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (selVec[i]) begin
        allN = 1'b0;
        if (halted[i]) begin anyH = 1'b1; allR = 1'b0; end
        else           begin anyR = 1'b1; allH = 1'b0; end
        if (resumeAck[i]) anyA = 1'b1; else allA = 1'b0;
        if (haveReset[i]) anyHR = 1'b1; else allHR = 1'b0;
      end
    end
    statusBits = {anyHR, allHR, !selExists, allN, anyA, allA, anyR, allR, anyH, allH};
  end

  always_comb begin
    winWord = '0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (winSel == WSEL_W'(i / 32)) winWord[i % 32] = mask[i];
    end
  end

  always_comb begin
    regRdata = '0;
    case (rcAddr_e'(regAddr))
      ADDR_CTRL: begin
        regRdata[0] = strobes.active;
        regRdata[1] = strobes.haltLvl;
        regRdata[3] = strobes.arraySel;
        regRdata[CTRL_SEL_LSB +: SEL_W] = sel;
      end
      ADDR_STATUS: regRdata[9:0] = statusBits;
      ADDR_WINSEL: regRdata[WSEL_W-1:0] = winSel;
      ADDR_WINDOW: regRdata = winWord;
      ADDR_GROUP:  regRdata[GROUP_W-1:0] = grpOfSel;
      default:     regRdata = '0;
    endcase
  end

  assign haltReq   = ({NUM_HARTS{strobes.active & strobes.haltLvl}} & selVec) | grpReq;
  assign resumeReq = resumeFlag;

endmodule

// File: rtl/hart_runctl.sv
module hart_runctl
  import hart_runctl_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int GROUP_W   = 5,
  parameter bit ARRAY_EN  = 1'b1,
  parameter bit GROUPS_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [2:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [NUM_HARTS-1:0] hartHalted,
  input  logic [NUM_HARTS-1:0] hartResuming,
  input  logic [NUM_HARTS-1:0] hartResetEvt,
  output logic [NUM_HARTS-1:0] haltReq,
  output logic [NUM_HARTS-1:0] resumeReq
);

  localparam int SEL_W  = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam int NWIN   = (NUM_HARTS + 31) / 32;
  localparam int WSEL_W = (NWIN > 1) ? $clog2(NWIN) : 1;

  rcStrobe_t         strobes;
  logic [SEL_W-1:0]  sel;
  logic [WSEL_W-1:0] winSel;

  hart_runctl_ctrl #(
    .SEL_W(SEL_W), .WSEL_W(WSEL_W), .ARRAY_EN(ARRAY_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strobes(strobes), .sel(sel), .winSel(winSel)
  );

  hart_runctl_dp #(
    .NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W), .WSEL_W(WSEL_W),
    .GROUP_W(GROUP_W), .ARRAY_EN(ARRAY_EN), .GROUPS_EN(GROUPS_EN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sel(sel), .winSel(winSel),
    .regAddr(regAddr), .regWdata(regWdata), .hartHalted(hartHalted),
    .hartResuming(hartResuming), .hartResetEvt(hartResetEvt),
    .regRdata(regRdata), .haltReq(haltReq), .resumeReq(resumeReq)
  );

endmodule

// File: rtl/hart_runctl_chk.sv
module hart_runctl_chk #(
  parameter int NUM_HARTS = 4,
  parameter int SEL_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWe,
  input logic [2:0]           regAddr,
  input logic [31:0]          regWdata,
  input logic [31:0]          regRdata,
  input logic [NUM_HARTS-1:0] hartResuming,
  input logic [NUM_HARTS-1:0] hartResetEvt,
  input logic [NUM_HARTS-1:0] resumeReq
);

  // R6: a resuming pulse drops that hart's resume flag unless a control write competes
  assert_resume_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWe && regAddr == 3'd0) && hartResuming != '0 && (hartResuming & hartResetEvt) == '0)
    |=> (resumeReq & $past(hartResuming)) == '0);

  // R11: an inactive control write never raises a resume flag
  assert_inactive_noresume_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd0 && !regWdata[0])
    |=> (resumeReq & ~$past(resumeReq)) == '0);

  // R4: an out-of-range index alone reports all and any nonexistent
  assert_nonexist_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd0 && regWdata[0] && !regWdata[3] &&
     {1'b0, regWdata[8 +: SEL_W]} >= (SEL_W+1)'(NUM_HARTS))
    |=> (regWe || regAddr != 3'd1 || regRdata[7:6] == 2'b11));

  // R3: any-halted excludes all-running
  assert_summary_halt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd1 && regRdata[1]) |-> !regRdata[2]);

  // R3: all-halted together with all-running only when nothing exists
  assert_summary_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd1 && regRdata[0] && regRdata[2]) |-> regRdata[6]);

endmodule

bind hart_runctl hart_runctl_chk #(.NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .hartResuming(hartResuming), .hartResetEvt(hartResetEvt),
  .resumeReq(resumeReq)
);

// File: tb/hart_runctl_tb.sv
module hart_runctl_tb;

  localparam int N = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [2:0]    regAddr = 3'd0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [N-1:0]  hartHalted = '0, hartResuming = '0, hartResetEvt = '0;
  logic [N-1:0]  haltReq, resumeReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hart_runctl #(.NUM_HARTS(N), .GROUP_W(4), .ARRAY_EN(1'b1), .GROUPS_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .hartHalted(hartHalted), .hartResuming(hartResuming),
    .hartResetEvt(hartResetEvt), .haltReq(haltReq), .resumeReq(resumeReq)
  );

  function automatic logic [31:0] ctl(bit act, bit hlt, bit res, bit arr, int s);
    return {16'd0, 8'(s), 4'd0, arr, res, hlt, act};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  // kind: 0 halted, 1 resuming, 2 reset
  task automatic ev(int kind, logic [N-1:0] v);
    @(negedge clk);
    if (kind == 0) hartHalted = v; else if (kind == 1) hartResuming = v; else hartResetEvt = v;
    @(negedge clk);
    hartHalted = '0; hartResuming = '0; hartResetEvt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd1, d); chk("R1 status after reset", 64'(d), 64'h00C);
    rd(3'd0, d); chk("R1 ctrl after reset", 64'(d), 64'h0);
    rd(3'd3, d); chk("R1 window after reset", 64'(d), 64'h0);
    chk("R1 haltReq after reset", 64'(haltReq), 64'h0);
    chk("R1 resumeReq after reset", 64'(resumeReq), 64'h0);
  endtask

  task automatic t_halt_single();
    logic [31:0] d;
    wr(3'd0, ctl(1, 1, 0, 0, 5));
    chk("R5 haltReq single index", 64'(haltReq), 64'h20);
    rd(3'd0, d); chk("R2 ctrl readback", 64'(d), 64'h503);
    ev(0, N'(1) << 5);
    rd(3'd1, d); chk("R3 status hart5 halted", 64'(d), 64'h003);
    wr(3'd0, ctl(1, 0, 0, 0, 5));
    chk("R5 haltReq dropped", 64'(haltReq), 64'h0);
  endtask

  task automatic t_resume();
    logic [31:0] d;
    wr(3'd0, ctl(1, 0, 1, 0, 5));
    chk("R6 resume flag raised", 64'(resumeReq), 64'h20);
    rd(3'd0, d); chk("R2 resume bit reads 0", 64'(d), 64'h501);
    ev(1, N'(1) << 5);
    chk("R6 resume flag cleared", 64'(resumeReq), 64'h0);
    rd(3'd1, d); chk("R6 status after resuming", 64'(d), 64'h03C);
  endtask

  task automatic t_array();
    logic [31:0] d;
    wr(3'd2, 32'd0); wr(3'd3, 32'h30);
    wr(3'd2, 32'd1); wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R9 window1 missing harts read 0", 64'(d), 64'hF);
    rd(3'd2, d); chk("R9 window select readback", 64'(d), 64'h1);
    wr(3'd2, 32'd0);
    rd(3'd3, d); chk("R9 window0 readback", 64'(d), 64'h30);
    wr(3'd0, ctl(1, 0, 0, 1, 0));
    rd(3'd1, d); chk("R3 mask selection running", 64'(d), 64'h02C);
    wr(3'd0, ctl(1, 1, 0, 1, 0));
    chk("R2 haltReq over mask", 64'(haltReq), 64'hF_0000_0031);
    ev(0, N'(1) << 4);
    rd(3'd1, d); chk("R3 mixed halted/running", 64'(d), 64'h02A);
  endtask

  task automatic t_nonexist();
    logic [31:0] d;
    wr(3'd0, ctl(1, 1, 0, 0, 40));
    rd(3'd1, d); chk("R4 index 40 alone", 64'(d), 64'h1D5);
    chk("R4 no haltReq for missing hart", 64'(haltReq), 64'h0);
    wr(3'd0, ctl(1, 0, 0, 1, 40));
    rd(3'd1, d); chk("R4 index 40 with mask", 64'(d), 64'h0AA);
  endtask

  task automatic t_groups();
    logic [31:0] d;
    for (int h = 1; h <= 3; h++) begin
      wr(3'd0, ctl(1, 0, 0, 0, h));
      wr(3'd4, 32'h8000_0003);
    end
    wr(3'd0, ctl(1, 0, 0, 0, 1));
    rd(3'd4, d); chk("R10 group written", 64'(d), 64'h3);
    wr(3'd4, 32'h0000_0005);
    rd(3'd4, d); chk("R10 no enable bit, group kept", 64'(d), 64'h3);
    wr(3'd0, ctl(1, 0, 0, 0, 40));
    wr(3'd4, 32'h8000_0007);
    rd(3'd4, d); chk("R10 missing hart group reads 0", 64'(d), 64'h0);
    wr(3'd0, ctl(1, 0, 0, 0, 0));
    ev(0, N'(1) << 6);
    chk("R7 group 0 does not spread", 64'(haltReq), 64'h0);
    ev(0, N'(1) << 1);
    chk("R7 halt spreads to group", 64'(haltReq), 64'hC);
    ev(0, N'(1) << 2);
    chk("R7 request drops on own halt", 64'(haltReq), 64'h8);
    ev(2, N'(1) << 3);
    chk("R8 reset drops group request", 64'(haltReq), 64'h0);
    wr(3'd0, ctl(1, 0, 0, 0, 3));
    rd(3'd4, d); chk("R8 reset clears group", 64'(d), 64'h0);
    rd(3'd1, d); chk("R8 have-reset status", 64'(d), 64'h30C);
  endtask

  task automatic t_inactive();
    logic [31:0] d;
    wr(3'd0, ctl(0, 1, 1, 1, 7));
    rd(3'd0, d); chk("R11 ctrl cleared", 64'(d), 64'h0);
    chk("R11 no halt request", 64'(haltReq), 64'h0);
    chk("R11 no resume flag", 64'(resumeReq), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt_single();
    t_resume();
    t_array();
    t_nonexist();
    t_groups();
    t_inactive();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule